// File: doc/BRIEF.md
# RAM Region Write Protection Unit

This unit sits on the CPU's path into on-chip RAM and divides that RAM into three areas in 256-byte pages: a coprocessor-owned area that starts at the lowest implemented RAM page, a shared area, and a CPU-owned area made of every remaining RAM page. Three 8-bit page registers set the edges. The page named by each register belongs to its area.

While protection is armed, a CPU write that lands in the coprocessor area is blocked in the same cycle. Reads and writes elsewhere pass unchanged. A blocked write latches a sticky violation flag. When interrupts are enabled, that flag drives an interrupt request. A plain register write port programs the page registers and the control bits. Software clears the flag by writing 1 to it.

Top module: `ram_wprot_unit`

## Requirements
- R1: The page number is cpu_addr[15:8]. An address is in RAM only when cpu_addr[19:16] equals 0xF and the page is at least 0x80. Any other address reports region code 0 and is never blocked.
- R2: A RAM page from 0x80 up to and including the coprocessor upper register reports region code 1 (coprocessor).
- R3: A RAM page from the shared lower register up to and including the shared upper register reports region code 3 (shared). With 0xC1 and 0xE0 in these registers, addresses 0x0F_C100 through 0x0F_E0FF are shared and 0x0F_C0FF and 0x0F_E100 are not.
- R4: A RAM page outside both areas reports region code 2 (CPU).
- R5: When a page is in both the coprocessor area and the shared area, the coprocessor area takes priority. The page reports code 1 and a write to it can be blocked.
- R6: When the protection bit is set, a CPU write to region code 1 holds mem_wr_en low and raises blocked in the same cycle.
- R7: Reads always raise mem_rd_en and are never blocked. Writes to regions 0, 2 and 3 always pass. When the protection bit is clear, no write is blocked and the violation flag does not set.
- R8: A blocked write sets viol_flag in the following cycle. The flag stays set until a control write has bit 7 at 1. A control write with bit 7 at 0 leaves the flag alone. If a block and a clear fall in the same cycle, the set wins.
- R9: irq is high exactly when viol_flag and the interrupt enable bit are both set.
- R10: Register offsets: 0 holds the coprocessor upper page, 1 the shared lower page, 2 the shared upper page, 3 the control register. In the control register, bit 0 is the protection enable, bit 1 the interrupt enable, and bit 7 the flag clear. Writes take effect on the next clock edge. After reset all registers and the flag are zero, so every RAM page reports code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| cpu_valid | input | 1 | CPU RAM access request |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | CPU byte address |
| region | output | 2 | Region code of cpu_addr (0 none, 1 coprocessor, 2 CPU, 3 shared) |
| mem_wr_en | output | 1 | Write strobe passed on to the RAM |
| mem_rd_en | output | 1 | Read strobe passed on to the RAM |
| blocked | output | 1 | Current write is being suppressed |
| viol_flag | output | 1 | Sticky violation flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that cpu_write has meaning only while cpu_valid is high. They also assume that a flag clear arrives only through a control write. The boundary ordering rule (coprocessor upper below shared lower, shared lower not above shared upper) is not assumed by any property. The stimulus keeps that ordering in every case except one, where it deliberately lets the coprocessor area overlap the shared area to check the priority rule. Register writes and CPU accesses are driven on the falling edge and held for one full cycle, so every request is seen at exactly one rising edge.

// File: rtl/ram_wprot_pkg.sv
package ram_wprot_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_COP  = 2'd1,
      RGN_CPU  = 2'd2,
      RGN_SHR  = 2'd3
   } region_e;

   localparam logic [1:0] OFS_COP_HI = 2'd0;
   localparam logic [1:0] OFS_SHR_LO = 2'd1;
   localparam logic [1:0] OFS_SHR_HI = 2'd2;
   localparam logic [1:0] OFS_CTRL   = 2'd3;

   localparam int CTRL_PROT_BIT = 0;
   localparam int CTRL_IRQE_BIT = 1;
   localparam int CTRL_CLR_BIT  = 7;

   typedef struct packed {
      logic [7:0] cop_hi;
      logic [7:0] shr_lo;
      logic [7:0] shr_hi;
      logic       prot_en;
      logic       irq_en;
   } cfg_t;

endpackage

// File: rtl/ram_wprot_regs.sv
module ram_wprot_regs
   import ram_wprot_pkg::*;
#(
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_ofs,
   input  logic [PAGE_W-1:0] wr_data,
   output cfg_t              cfg,
   output logic              flag_clr
);

   localparam int CTRL_W = CTRL_CLR_BIT + 1;

   logic [PAGE_W-1:0] cop_hi_q, shr_lo_q, shr_hi_q;
   logic              prot_q, irqe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cop_hi_q <= '0;
         shr_lo_q <= '0;
         shr_hi_q <= '0;
         prot_q   <= 1'b0;
         irqe_q   <= 1'b0;
      end else if (wr_en) begin
         case (wr_ofs)
            OFS_COP_HI: cop_hi_q <= wr_data;
            OFS_SHR_LO: shr_lo_q <= wr_data;
            OFS_SHR_HI: shr_hi_q <= wr_data;
            default: begin
               prot_q <= wr_data[CTRL_PROT_BIT];
               irqe_q <= wr_data[CTRL_IRQE_BIT];
            end
         endcase
      end
   end

   generate
      if (PAGE_W < CTRL_W) begin : g_bad_width
         $error("ram_wprot_regs: PAGE_W too narrow for control register");
      end
   endgenerate

   assign flag_clr = wr_en && (wr_ofs == OFS_CTRL) && wr_data[CTRL_CLR_BIT];

   always_comb begin
      cfg.cop_hi  = cop_hi_q;
      cfg.shr_lo  = shr_lo_q;
      cfg.shr_hi  = shr_hi_q;
      cfg.prot_en = prot_q;
      cfg.irq_en  = irqe_q;
   end

endmodule

// File: rtl/ram_wprot_decode.sv
module ram_wprot_decode
   import ram_wprot_pkg::*;
#(
   parameter int          HI_W        = 12,
   parameter int          PAGE_W      = 8,
   parameter int unsigned RAM_TAG     = 32'hF,
   parameter int unsigned RAM_LO_PAGE = 32'h80
) (
   input  logic [HI_W-1:0] blk_addr,
   input  cfg_t            cfg,
   output region_e         region
);

   localparam int TAG_W = HI_W - PAGE_W;
   localparam logic [PAGE_W-1:0] LO_PG = PAGE_W'(RAM_LO_PAGE);

   logic [PAGE_W-1:0] page;
   logic              tag_hit;
   logic              in_ram, in_cop, in_shr;

   assign page = blk_addr[PAGE_W-1:0];

   generate
      if (TAG_W > 0) begin : g_tagged
         assign tag_hit = (blk_addr[HI_W-1:PAGE_W] == TAG_W'(RAM_TAG));
      end else begin : g_flat
         assign tag_hit = 1'b1;
      end
   endgenerate

   assign in_ram = tag_hit && (page >= LO_PG);
   assign in_cop = in_ram && (page <= cfg.cop_hi);
   assign in_shr = in_ram && (page >= cfg.shr_lo) && (page <= cfg.shr_hi);

   always_comb begin
      if (!in_ram)      region = RGN_NONE;
      else if (in_cop)  region = RGN_COP;
      else if (in_shr)  region = RGN_SHR;
      else              region = RGN_CPU;
   end

endmodule

// File: rtl/ram_wprot_flag.sv
module ram_wprot_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_en_i;

endmodule

// File: rtl/ram_wprot_unit.sv
module ram_wprot_unit
   import ram_wprot_pkg::*;
#(
   parameter int          ADDR_W      = 20,
   parameter int          BLK_LSB     = 8,
   parameter int          PAGE_W      = 8,
   parameter int unsigned RAM_TAG     = 32'hF,
   parameter int unsigned RAM_LO_PAGE = 32'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic [1:0]        region,
   output logic              mem_wr_en,
   output logic              mem_rd_en,
   output logic              blocked,
   output logic              viol_flag,
   output logic              irq
);

   localparam int HI_W = ADDR_W - BLK_LSB;

   generate
      if (HI_W < PAGE_W) begin : g_bad_addr
         $error("ram_wprot_unit: ADDR_W too small for page field");
      end
      if (PAGE_W != 8) begin : g_bad_page
         $error("ram_wprot_unit: boundary registers are 8 bits wide");
      end
      if (RAM_LO_PAGE >= (32'd1 << PAGE_W)) begin : g_bad_lo
         $error("ram_wprot_unit: RAM_LO_PAGE out of range");
      end
   endgenerate

   cfg_t    cfg;
   logic    flag_clr;
   region_e rgn;
   logic    unused_ofs;

   assign unused_ofs = &{1'b0, cpu_addr[BLK_LSB-1:0]};

   ram_wprot_regs #(.PAGE_W(PAGE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we),
      .wr_ofs   (reg_addr),
      .wr_data  (reg_wdata),
      .cfg      (cfg),
      .flag_clr (flag_clr)
   );

   ram_wprot_decode #(
      .HI_W        (HI_W),
      .PAGE_W      (PAGE_W),
      .RAM_TAG     (RAM_TAG),
      .RAM_LO_PAGE (RAM_LO_PAGE)
   ) u_decode (
      .blk_addr (cpu_addr[ADDR_W-1:BLK_LSB]),
      .cfg      (cfg),
      .region   (rgn)
   );

   assign blocked   = cfg.prot_en && cpu_valid && cpu_write && (rgn == RGN_COP);
   assign mem_wr_en = cpu_valid && cpu_write && !blocked;
   assign mem_rd_en = cpu_valid && !cpu_write;
   assign region    = rgn;

   ram_wprot_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (blocked),
      .clr_i    (flag_clr),
      .irq_en_i (cfg.irq_en),
      .flag_o   (viol_flag),
      .irq_o    (irq)
   );

endmodule

// File: rtl/ram_wprot_chk.sv
module ram_wprot_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_we,
   input logic [1:0] reg_addr,
   input logic [7:0] reg_wdata,
   input logic       cpu_valid,
   input logic       cpu_write,
   input logic [1:0] region,
   input logic       mem_wr_en,
   input logic       mem_rd_en,
   input logic       blocked,
   input logic       viol_flag,
   input logic       irq
);

   // R6
   blocked_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> (!mem_wr_en && cpu_write && region == 2'd1));

   // R7
   read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_write) |-> (mem_rd_en && !blocked));

   // R7
   other_region_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_write && region != 2'd1) |-> mem_wr_en);

   // R8
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> viol_flag);

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flag && !(reg_we && reg_addr == 2'd3 && reg_wdata[7])) |=> viol_flag);

   // R8
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_flag) |-> $past(blocked));

   // R9
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> viol_flag);

endmodule

bind ram_wprot_unit ram_wprot_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .cpu_valid (cpu_valid),
   .cpu_write (cpu_write),
   .region    (region),
   .mem_wr_en (mem_wr_en),
   .mem_rd_en (mem_rd_en),
   .blocked   (blocked),
   .viol_flag (viol_flag),
   .irq       (irq)
);

// File: tb/ram_wprot_unit_test.sv
`timescale 1ns/1ps
module ram_wprot_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        cpu_valid = 1'b0;
   logic        cpu_write = 1'b0;
   logic [19:0] cpu_addr = '0;
   logic [1:0]  region;
   logic        mem_wr_en, mem_rd_en, blocked, viol_flag, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ram_wprot_unit uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
      .cpu_addr(cpu_addr), .region(region), .mem_wr_en(mem_wr_en),
      .mem_rd_en(mem_rd_en), .blocked(blocked), .viol_flag(viol_flag), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // one access held for one rising edge; returns at the next falling edge, idle
   task automatic probe(input logic w, input logic [19:0] a, input logic [1:0] exp_rgn,
                        input logic exp_blk, input string req);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_write = w; cpu_addr = a;
      #1;
      check({req, " region"}, region, exp_rgn);
      check({req, " blocked"}, blocked, exp_blk);
      if (w) check({req, " mem_wr_en"}, mem_wr_en, !exp_blk);
      else   check({req, " mem_rd_en"}, mem_rd_en, 1'b1);
      @(negedge clk);
      cpu_valid = 1'b0; cpu_write = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      #1;
      check("R10 reset flag", viol_flag, 1'b0);
      check("R10 reset irq", irq, 1'b0);
      probe(1'b1, 20'hF_8000, 2'd2, 1'b0, "R10 reset low page is CPU");
      probe(1'b1, 20'hF_FF00, 2'd2, 1'b0, "R10 reset top page is CPU");
   endtask

   task automatic t_decode;
      reg_wr(2'd0, 8'h9F);
      reg_wr(2'd1, 8'hC1);
      reg_wr(2'd2, 8'hE0);
      probe(1'b0, 20'hF_8000, 2'd1, 1'b0, "R2 lowest page");
      probe(1'b0, 20'hF_9FFF, 2'd1, 1'b0, "R2 inclusive top");
      probe(1'b0, 20'hF_A000, 2'd2, 1'b0, "R4 above coprocessor");
      probe(1'b0, 20'hF_C0FF, 2'd2, 1'b0, "R3 below shared");
      probe(1'b0, 20'hF_C100, 2'd3, 1'b0, "R3 shared start");
      probe(1'b0, 20'hF_E0FF, 2'd3, 1'b0, "R3 shared end");
      probe(1'b0, 20'hF_E100, 2'd2, 1'b0, "R4 above shared");
      probe(1'b0, 20'hF_7FFF, 2'd0, 1'b0, "R1 below RAM");
      probe(1'b0, 20'hE_9000, 2'd0, 1'b0, "R1 wrong tag");
   endtask

   task automatic t_unprotected;
      probe(1'b1, 20'hF_8800, 2'd1, 1'b0, "R7 protection off");
      check("R7 flag stays clear", viol_flag, 1'b0);
   endtask

   task automatic t_blocking;
      reg_wr(2'd3, 8'h01);
      probe(1'b0, 20'hF_9000, 2'd1, 1'b0, "R7 read of coprocessor area");
      check("R7 read sets no flag", viol_flag, 1'b0);
      probe(1'b1, 20'hF_D000, 2'd3, 1'b0, "R7 shared write");
      probe(1'b1, 20'hF_B000, 2'd2, 1'b0, "R7 CPU write");
      probe(1'b1, 20'hE_9000, 2'd0, 1'b0, "R7 outside RAM write");
      check("R7 passing writes set no flag", viol_flag, 1'b0);
      probe(1'b1, 20'hF_9000, 2'd1, 1'b1, "R6 coprocessor write");
      check("R8 flag set", viol_flag, 1'b1);
      check("R9 irq disabled", irq, 1'b0);
      probe(1'b1, 20'hF_B000, 2'd2, 1'b0, "R8 later legal write");
      check("R8 flag sticky", viol_flag, 1'b1);
   endtask

   task automatic t_irq;
      reg_wr(2'd3, 8'h03);
      #1;
      check("R9 irq on", irq, 1'b1);
      check("R8 bit7 zero keeps flag", viol_flag, 1'b1);
      reg_wr(2'd3, 8'h83);
      #1;
      check("R8 w1c clears", viol_flag, 1'b0);
      check("R9 irq off", irq, 1'b0);
   endtask

   task automatic t_set_wins;
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h83;
      cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 20'hF_9000;
      @(negedge clk);
      reg_we = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0;
      #1;
      check("R8 set beats clear", viol_flag, 1'b1);
      check("R9 irq with flag", irq, 1'b1);
      reg_wr(2'd3, 8'h81);
      #1;
      check("R9 irq enable cleared", irq, 1'b0);
   endtask

   task automatic t_priority;
      reg_wr(2'd0, 8'hC8);
      probe(1'b1, 20'hF_C500, 2'd1, 1'b1, "R5 overlap page");
      probe(1'b1, 20'hF_D000, 2'd3, 1'b0, "R5 shared beyond overlap");
      reg_wr(2'd3, 8'h00);
      probe(1'b1, 20'hF_C500, 2'd1, 1'b0, "R7 disarmed overlap write");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_decode();
      t_unprotected();
      t_blocking();
      t_irq();
      t_set_wins();
      t_priority();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule